// File: doc/BRIEF.md
# Lead Permutation Verdict Logic

This block judges a three-lead semiconductor from the results of a scan over every way of assigning the leads to the collector, base and emitter roles. A test engine applies each of the six assignments in turn. For each assignment it reports whether it saw NPN-type gain and whether it saw PNP-type gain. The block keeps those flags and waits until all six assignments have reported. It then decides whether the part is good, which polarity it has, and which assignment connects it correctly. For a thyristor it decides instead which leads are the gate and the cathode.

A scan begins with a start pulse. The pulse clears the stored flags and the last verdict, and it captures the drive strength and the device class for that scan. Results arrive as strobes that carry a position index and two flags, and they may arrive in any order. A later strobe for the same position replaces the earlier one. Once every position has reported, the verdict is computed and held. It stays unchanged until the next start pulse.

The six positions are numbered 0 to 5. Each is written as (collector lead, base lead, emitter lead):

| Position | Assignment |
|----------|------------|
| 0 | (0,1,2) |
| 1 | (2,1,0) |
| 2 | (1,0,2) |
| 3 | (2,0,1) |
| 4 | (0,2,1) |
| 5 | (1,2,0) |

With this order, the two positions that share a base lead are 2k and 2k+1, and they differ only by a collector/emitter swap. Positions 5 and 0 are not counted as adjacent.

Top module: `lead_perm_judge`

## Requirements
- R1: The base lead of position p is 1 for p in {0,1}, 0 for p in {2,3} and 2 for p in {4,5}, as the SCR gate and cathode outputs show.
- R2: On a cycle with `start_i` high, the stored flags and the verdict outputs are cleared (`done_o`=0, all outputs 0). `drive_lo_i` and `scr_mode_i` are captured and used for that scan even if they change later. A strobe in the same cycle as `start_i` is dropped.
- R3: `done_o` stays 0 until all six positions have reported since the last start. It rises one clock after the edge that accepts the last missing position.
- R4: In HI drive (`drive_lo_i`=0) with transistor class, the part is good when one polarity passes in exactly positions 2k and 2k+1 and the other polarity passes nowhere. `polarity_o` is then 1 for NPN and 2 for PNP, and `conn_pos_o` is 2k.
- R5: In LO drive (`drive_lo_i`=1) with transistor class, the part is good when exactly one position passes, for one polarity only. `polarity_o` is 1 for NPN and 2 for PNP, and `conn_pos_o` is that position.
- R6: In SCR class (`scr_mode_i`=1, any drive), the part is good when exactly one position passes NPN and exactly one passes PNP, and the two have different base leads. `gate_lead_o` is then the base lead of the NPN pass, `cathode_lead_o` is the base lead of the PNP pass, and `polarity_o` and `conn_pos_o` are 0.
- R7: Any other pattern gives `good_o`=0 with `polarity_o`, `conn_pos_o`, `gate_lead_o` and `cathode_lead_o` all 0. This includes three passes, a non-pair adjacency, and an SCR with a shared base lead.
- R8: A second strobe for a position before the verdict replaces that position's flags.
- R9: After `done_o` rises, strobes have no effect. The verdict outputs hold until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a new scan; clears flags and verdict |
| drive_lo_i | input | 1 | 1 = LO drive, 0 = HI drive (captured at start) |
| scr_mode_i | input | 1 | 1 = SCR class, 0 = transistor (captured at start) |
| res_valid_i | input | 1 | Result strobe for one position |
| res_pos_i | input | 3 | Position index 0..5 of the strobe |
| res_npn_i | input | 1 | NPN gain seen at that position |
| res_pnp_i | input | 1 | PNP gain seen at that position |
| done_o | output | 1 | Verdict valid and held |
| good_o | output | 1 | Part judged good |
| polarity_o | output | 2 | 0 none, 1 NPN, 2 PNP |
| conn_pos_o | output | 3 | Correctly connected position |
| gate_lead_o | output | 2 | SCR gate lead index |
| cathode_lead_o | output | 2 | SCR cathode lead index |

## Verification
The assertions assume that `res_pos_i` is in range whenever `res_valid_i` is high. They also assume that start pulses come only from the scan controller. The bench's driver only ever issues position indices 0 to 5, and it opens every scan with a single-cycle start. Mode inputs are changed mid-scan only in the one case that checks the capture at start. Stray strobes are sent only after a verdict, to show that they are ignored.

// File: rtl/lead_perm_pkg.sv
// Shared constants, verdict type and position-to-base-lead map.
// Assumes the fixed six-position scan order given in the brief.
package lead_perm_pkg;
    localparam int NUM_LEADS = 3;
    localparam int NUM_POS   = 6;
    localparam int POS_W     = $clog2(NUM_POS);
    localparam int LEAD_W    = $clog2(NUM_LEADS);
    localparam int CNT_W     = $clog2(NUM_POS + 1);

    typedef enum logic [1:0] {
        POL_NONE = 2'd0,
        POL_NPN  = 2'd1,
        POL_PNP  = 2'd2
    } pol_e;

    typedef struct packed {
        logic              good;
        pol_e              pol;
        logic [POS_W-1:0]  conn;
        logic [LEAD_W-1:0] gate;
        logic [LEAD_W-1:0] cath;
    } verdict_t;

    // Lead placed on the base role by a given position.
    function automatic logic [LEAD_W-1:0] base_lead(input logic [POS_W-1:0] pos);
        case (pos)
            3'd0, 3'd1: base_lead = 2'd1;
            3'd2, 3'd3: base_lead = 2'd0;
            default:    base_lead = 2'd2;
        endcase
    endfunction
endpackage

// File: rtl/perm_result_store.sv
// Holds the NPN/PNP pass flags and a "reported" mask for each position.
// Assumes pos_i < NUM_POS when valid_i is high; freeze_i blocks updates.
module perm_result_store
    import lead_perm_pkg::*;
#(
    parameter int N = NUM_POS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 freeze_i,
    input  logic                 valid_i,
    input  logic [POS_W-1:0]     pos_i,
    input  logic                 npn_i,
    input  logic                 pnp_i,
    output logic [N-1:0]         npn_o,
    output logic [N-1:0]         pnp_o,
    output logic                 all_seen_o
);
    logic [N-1:0] npn_q, pnp_q, seen_q;
    logic         accept;

    // Purpose: a strobe is taken only outside clear and freeze.
    assign accept = valid_i && !clear_i && !freeze_i;

    // One flag triple per position, generated.
    for (genvar p = 0; p < N; p++) begin : g_pos
        // Purpose: clear on start, overwrite on matching strobe.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i) begin
                npn_q[p]  <= 1'b0;
                pnp_q[p]  <= 1'b0;
                seen_q[p] <= 1'b0;
            end else if (accept && (pos_i == POS_W'(p))) begin
                npn_q[p]  <= npn_i;
                pnp_q[p]  <= pnp_i;
                seen_q[p] <= 1'b1;
            end
        end
    end

    assign npn_o      = npn_q;
    assign pnp_o      = pnp_q;
    assign all_seen_o = &seen_q;

    // R2
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (seen_q == '0 && npn_q == '0 && pnp_q == '0));

    // R9
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_i && !clear_i) |=> ($stable(npn_q) && $stable(pnp_q) && $stable(seen_q)));

    // R3
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |-> (pos_i < POS_W'(N)));
endmodule

// File: rtl/perm_pass_scan.sv
// Summarises one polarity's pass vector: count, lowest set index, and
// whether the set is exactly an aligned pair {2k, 2k+1}. Pure logic.
module perm_pass_scan
    import lead_perm_pkg::*;
#(
    parameter int N = NUM_POS
) (
    input  logic [N-1:0]      hits_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [POS_W-1:0]  first_o,
    output logic              pair_o
);
    localparam int NPAIR = N / 2;
    logic [NPAIR-1:0] pair_hit;

    // Purpose: population count of passing positions.
    always_comb cnt_o = CNT_W'($countones(hits_i));

    // Purpose: lowest-index passing position (0 when none).
    always_comb begin
        first_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits_i[i]) first_o = POS_W'(i);
        end
    end

    // One matcher per aligned pair.
    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        assign pair_hit[k] = (hits_i == (N'(2'b11) << (2 * k)));
    end

    assign pair_o = |pair_hit;
endmodule

// File: rtl/perm_verdict_eval.sv
// Combinational rule engine: applies the HI, LO or SCR rule to the stored
// flags and forms the verdict. Assumes flags are complete when consumed.
module perm_verdict_eval
    import lead_perm_pkg::*;
#(
    parameter int N = NUM_POS
) (
    input  logic [N-1:0] npn_i,
    input  logic [N-1:0] pnp_i,
    input  logic         drive_lo_i,
    input  logic         scr_i,
    output verdict_t     verdict_o
);
    logic [CNT_W-1:0] n_cnt, p_cnt;
    logic [POS_W-1:0] n_first, p_first;
    logic             n_pair, p_pair;

    perm_pass_scan #(.N(N)) u_npn_scan (
        .hits_i (npn_i), .cnt_o (n_cnt), .first_o (n_first), .pair_o (n_pair));

    perm_pass_scan #(.N(N)) u_pnp_scan (
        .hits_i (pnp_i), .cnt_o (p_cnt), .first_o (p_first), .pair_o (p_pair));

    // Purpose: select the rule for the captured mode and build the verdict.
    always_comb begin
        verdict_o = '0;
        if (scr_i) begin
            if (n_cnt == CNT_W'(1) && p_cnt == CNT_W'(1)
                && base_lead(n_first) != base_lead(p_first)) begin
                verdict_o.good = 1'b1;
                verdict_o.gate = base_lead(n_first);
                verdict_o.cath = base_lead(p_first);
            end
        end else if (drive_lo_i) begin
            if (n_cnt == CNT_W'(1) && p_cnt == '0) begin
                verdict_o.good = 1'b1;
                verdict_o.pol  = POL_NPN;
                verdict_o.conn = n_first;
            end else if (p_cnt == CNT_W'(1) && n_cnt == '0) begin
                verdict_o.good = 1'b1;
                verdict_o.pol  = POL_PNP;
                verdict_o.conn = p_first;
            end
        end else begin
            if (n_pair && p_cnt == '0) begin
                verdict_o.good = 1'b1;
                verdict_o.pol  = POL_NPN;
                verdict_o.conn = n_first;
            end else if (p_pair && n_cnt == '0) begin
                verdict_o.good = 1'b1;
                verdict_o.pol  = POL_PNP;
                verdict_o.conn = p_first;
            end
        end
    end
endmodule

// File: rtl/lead_perm_judge.sv
// Top: captures mode at start, collects six position results, then
// latches and holds one verdict until the next start.
// Assumes res_pos_i is 0..5 whenever res_valid_i is high.
module lead_perm_judge
    import lead_perm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        drive_lo_i,
    input  logic        scr_mode_i,
    input  logic        res_valid_i,
    input  logic [2:0]  res_pos_i,
    input  logic        res_npn_i,
    input  logic        res_pnp_i,
    output logic        done_o,
    output logic        good_o,
    output logic [1:0]  polarity_o,
    output logic [2:0]  conn_pos_o,
    output logic [1:0]  gate_lead_o,
    output logic [1:0]  cathode_lead_o
);
    logic [NUM_POS-1:0] npn_flags, pnp_flags;
    logic               all_seen;
    logic               done_q, lo_q, scr_q;
    verdict_t           rule_v, held_q;

    perm_result_store #(.N(NUM_POS)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start_i),
        .freeze_i   (done_q),
        .valid_i    (res_valid_i),
        .pos_i      (res_pos_i),
        .npn_i      (res_npn_i),
        .pnp_i      (res_pnp_i),
        .npn_o      (npn_flags),
        .pnp_o      (pnp_flags),
        .all_seen_o (all_seen)
    );

    perm_verdict_eval #(.N(NUM_POS)) u_eval (
        .npn_i      (npn_flags),
        .pnp_i      (pnp_flags),
        .drive_lo_i (lo_q),
        .scr_i      (scr_q),
        .verdict_o  (rule_v)
    );

    // Purpose: capture the scan mode on each start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= 1'b0;
            scr_q <= 1'b0;
        end else if (start_i) begin
            lo_q  <= drive_lo_i;
            scr_q <= scr_mode_i;
        end
    end

    // Purpose: latch the verdict once when the result set is complete.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            done_q <= 1'b0;
            held_q <= '0;
        end else if (all_seen && !done_q) begin
            done_q <= 1'b1;
            held_q <= rule_v;
        end
    end

    assign done_o         = done_q;
    assign good_o         = held_q.good;
    assign polarity_o     = held_q.pol;
    assign conn_pos_o     = held_q.conn;
    assign gate_lead_o    = held_q.gate;
    assign cathode_lead_o = held_q.cath;

    // R3
    done_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(all_seen));

    // R7
    bad_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !good_o |-> (polarity_o == 2'd0 && conn_pos_o == 3'd0
                     && gate_lead_o == 2'd0 && cathode_lead_o == 2'd0));

    // R6
    scr_leads_differ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good_o && polarity_o == 2'd0) |-> (gate_lead_o != cathode_lead_o));

    // R4
    transistor_no_leads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good_o && polarity_o != 2'd0) |-> (gate_lead_o == 2'd0 && cathode_lead_o == 2'd0
                                             && polarity_o != 2'd3));

    // R9
    verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(good_o) && $stable(polarity_o)
                                  && $stable(conn_pos_o) && $stable(gate_lead_o)
                                  && $stable(cathode_lead_o)));

    // R2
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!done_o && !good_o));
endmodule

// File: tb/lead_perm_judge_tb_top.sv
module lead_perm_judge_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic       good;
        logic [1:0] pol;
        logic [2:0] conn;
        logic [1:0] gate;
        logic [1:0] cath;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, drive_lo_i = 1'b0, scr_mode_i = 1'b0;
    logic res_valid_i = 1'b0, res_npn_i = 1'b0, res_pnp_i = 1'b0;
    logic [2:0] res_pos_i = 3'd0;
    logic done_o, good_o;
    logic [1:0] polarity_o, gate_lead_o, cathode_lead_o;
    logic [2:0] conn_pos_o;

    int n_vec = 0, n_bad = 0;
    exp_t sb_q[$];
    logic done_prev = 1'b0;
    bit   finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lead_perm_judge dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .drive_lo_i(drive_lo_i),
        .scr_mode_i(scr_mode_i), .res_valid_i(res_valid_i), .res_pos_i(res_pos_i),
        .res_npn_i(res_npn_i), .res_pnp_i(res_pnp_i), .done_o(done_o), .good_o(good_o),
        .polarity_o(polarity_o), .conn_pos_o(conn_pos_o), .gate_lead_o(gate_lead_o),
        .cathode_lead_o(cathode_lead_o));

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic cmp_all(input exp_t e);
        check(e.tag, "good", int'(good_o), int'(e.good));
        check(e.tag, "polarity", int'(polarity_o), int'(e.pol));
        check(e.tag, "conn", int'(conn_pos_o), int'(e.conn));
        check(e.tag, "gate", int'(gate_lead_o), int'(e.gate));
        check(e.tag, "cathode", int'(cathode_lead_o), int'(e.cath));
    endtask

    // Monitor: pop one expected item on every rising done_o.
    always @(negedge clk) begin
        if (rst_n && done_o && !done_prev) begin
            if (sb_q.size() == 0) begin
                n_vec++; n_bad++;
                $display("FAIL R3 unexpected verdict: actual done 1 expected 0");
            end else begin
                cmp_all(sb_q.pop_front());
            end
        end
        done_prev = done_o;
    end

    task automatic begin_scan(input logic lo, input logic scr);
        @(negedge clk);
        start_i = 1'b1; drive_lo_i = lo; scr_mode_i = scr;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic send(input int pos, input logic n, input logic p);
        res_valid_i = 1'b1; res_pos_i = 3'(pos); res_npn_i = n; res_pnp_i = p;
        @(negedge clk);
        res_valid_i = 1'b0; res_npn_i = 1'b0; res_pnp_i = 1'b0;
    endtask

    task automatic wait_drain();
        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_vec++; n_bad++;
            $display("FAIL R3 verdict missing: actual pending %0d expected 0", sb_q.size());
            sb_q.delete();
        end
    endtask

    // Driver: a full scan with masks, in rotated order, expected item pushed.
    task automatic run_scan(input logic lo, input logic scr, input logic [5:0] nm,
                            input logic [5:0] pm, input int rot, input exp_t e);
        begin_scan(lo, scr);
        sb_q.push_back(e);
        for (int i = 0; i < 6; i++) begin
            int p;
            p = (i + rot) % 6;
            send(p, nm[p], pm[p]);
        end
        wait_drain();
    endtask

    function automatic exp_t mk(input logic g, input logic [1:0] pol, input logic [2:0] c,
                                input logic [1:0] ga, input logic [1:0] ca, input string t);
        exp_t e;
        e.good = g; e.pol = pol; e.conn = c; e.gate = ga; e.cath = ca; e.tag = t;
        return e;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", "reset done", int'(done_o), 0);
        check("R2", "reset good", int'(good_o), 0);

        // R4 good NPN, HI, pair {2,3}
        run_scan(0, 0, 6'b001100, 6'b000000, 0, mk(1, 2'd1, 3'd2, 0, 0, "R4"));
        // R9 stray strobe after verdict: outputs hold
        send(3, 1'b0, 1'b1);
        send(5, 1'b1, 1'b0);
        @(negedge clk);
        check("R9", "done held", int'(done_o), 1);
        cmp_all(mk(1, 2'd1, 3'd2, 0, 0, "R9"));
        // R2 start clears verdict
        begin_scan(0, 0);
        check("R2", "done cleared", int'(done_o), 0);
        check("R2", "good cleared", int'(good_o), 0);
        check("R2", "polarity cleared", int'(polarity_o), 0);

        // R4 good PNP, HI, pair {4,5}, scrambled order
        run_scan(0, 0, 6'b000000, 6'b110000, 3, mk(1, 2'd2, 3'd4, 0, 0, "R4"));
        // R4 good NPN pair {0,1}
        run_scan(0, 0, 6'b000011, 6'b000000, 5, mk(1, 2'd1, 3'd0, 0, 0, "R4"));
        // R7 adjacent but different base leads {1,2}
        run_scan(0, 0, 6'b000110, 6'b000000, 0, mk(0, 0, 0, 0, 0, "R7"));
        // R7 collector/emitter short: three passes
        run_scan(0, 0, 6'b000111, 6'b000000, 0, mk(0, 0, 0, 0, 0, "R7"));
        // R7 pair plus opposite polarity
        run_scan(0, 0, 6'b001100, 6'b000001, 0, mk(0, 0, 0, 0, 0, "R7"));
        // R5 LO single NPN at 3
        run_scan(1, 0, 6'b001000, 6'b000000, 2, mk(1, 2'd1, 3'd3, 0, 0, "R5"));
        // R5 LO single PNP at 5
        run_scan(1, 0, 6'b000000, 6'b100000, 0, mk(1, 2'd2, 3'd5, 0, 0, "R5"));
        // R7 LO with two passes
        run_scan(1, 0, 6'b001100, 6'b000000, 0, mk(0, 0, 0, 0, 0, "R7"));
        // R6 R1 SCR: NPN at 0 (base 1), PNP at 3 (base 0)
        run_scan(0, 1, 6'b000001, 6'b001000, 0, mk(1, 0, 0, 2'd1, 2'd0, "R6"));
        // R6 R1 SCR: NPN at 5 (base 2), PNP at 1 (base 1), LO drive
        run_scan(1, 1, 6'b100000, 6'b000010, 4, mk(1, 0, 0, 2'd2, 2'd1, "R1"));
        // R1 SCR: NPN at 2 (base 0), PNP at 4 (base 2)
        run_scan(0, 1, 6'b000100, 6'b010000, 1, mk(1, 0, 0, 2'd0, 2'd2, "R1"));
        // R7 SCR with shared base lead (positions 0 and 1)
        run_scan(0, 1, 6'b000001, 6'b000010, 0, mk(0, 0, 0, 0, 0, "R7"));
        // R7 SCR with two NPN passes
        run_scan(0, 1, 6'b000101, 6'b010000, 0, mk(0, 0, 0, 0, 0, "R7"));

        // R2 mode captured at start: LO scan, inputs flipped to HI mid-scan
        begin_scan(1, 0);
        sb_q.push_back(mk(1, 2'd1, 3'd1, 0, 0, "R2"));
        drive_lo_i = 1'b0; scr_mode_i = 1'b1;
        for (int p = 0; p < 6; p++) send(p, (p == 1), 1'b0);
        wait_drain();

        // R8 overwrite: pos1 NPN then pos1 cleared, pos4 NPN in LO
        begin_scan(1, 0);
        sb_q.push_back(mk(1, 2'd1, 3'd4, 0, 0, "R8"));
        send(1, 1'b1, 1'b0);
        send(1, 1'b0, 1'b0);
        for (int p = 0; p < 6; p++) if (p != 1) send(p, (p == 4), 1'b0);
        wait_drain();

        // R3 done only after all six, one clock after the last strobe edge
        begin_scan(0, 0);
        for (int p = 0; p < 5; p++) send(p, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check("R3", "done after five", int'(done_o), 0);
        sb_q.push_back(mk(0, 0, 0, 0, 0, "R3"));
        res_valid_i = 1'b1; res_pos_i = 3'd5;
        @(negedge clk);
        res_valid_i = 1'b0;
        check("R3", "done same edge", int'(done_o), 0);
        @(negedge clk);
        check("R3", "done next edge", int'(done_o), 1);
        wait_drain();

        // R2 strobe coincident with start is dropped
        @(negedge clk);
        start_i = 1'b1; drive_lo_i = 1'b1; scr_mode_i = 1'b0;
        res_valid_i = 1'b1; res_pos_i = 3'd0; res_npn_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; res_valid_i = 1'b0; res_npn_i = 1'b0;
        sb_q.push_back(mk(1, 2'd1, 3'd2, 0, 0, "R2"));
        for (int p = 1; p < 6; p++) send(p, (p == 2), 1'b0);
        repeat (2) @(negedge clk);
        check("R2", "done without pos0", int'(done_o), 0);
        send(0, 1'b0, 1'b0);
        wait_drain();

        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                n_vec++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule